// File: doc/BRIEF.md
# Fuse Array Read Controller

This block lets software fetch 16-bit words from a one-time-programmable fuse array over a plain register bus. The bus has an address, a write enable, write data and combinational read data. Software first sets the module enable bit and writes a block number. It then pulses the read command and polls the status register until the done flag appears. It collects the word from the read data register and finally writes the clear command.

The array contents arrive on a wide preload input that stands in for the physical fuses. Block `i` occupies bits `16*i+15 : 16*i` of that input. A sequencer holds the access busy for a programmable number of cycles, then latches the word. The done flag is sticky, so a slow poller cannot miss a completion. Burning fuses is not performed. The program command only shows a one-cycle busy pulse.

Register byte offsets: control 0x00 (module enable in bit 6), read data 0x04, write data 0x08, block number 0x0C, command 0x10, status 0x14, write timing 0x20, read timing 0x24, debounce setting 0x28. Command bits: bit 0 program, bit 1 read, bit 2 clear done. Status bits: bit 0 program busy, bit 1 read busy, bit 2 standby, bit 3 protect, bit 4 done. Writes to any other offset have no effect.

Top module: `fuse_read_ctrl`

## Requirements
- R1: After reset, status reads 0x04 while protect is low, and read data, block number and control all read 0.
- R2: The block number register keeps only bits 4:0, so writing 0xFF reads back 0x1F. Write data (32 bits), write timing, read timing and debounce setting (8 bits each) read back what was written. The command register always reads 0.
- R3: A read command is accepted only when module enable is 1 and status shows standby. A command written while disabled or while busy leaves status, done and read data unchanged.
- R4: After acceptance, standby is 0 and read busy is 1 for exactly max(read timing, 1) cycles.
- R5: At the end of the busy time, read data takes the word of the block number captured at acceptance, zero-extended to 32 bits. Done becomes 1, busy becomes 0 and standby becomes 1. Later writes to the block number do not change the result.
- R6: Done stays 1 until a write with command bit 2 set while enabled. Read data holds its value until the next read completes.
- R7: Writing module enable to 0 during a read ends it on the following cycle. Standby returns, done is not set and read data is unchanged.
- R8: Status bit 3 follows the protect input.
- R9: A program command while enabled and in standby sets program busy, and clears standby, for exactly one cycle. Array words read afterwards are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register byte offset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| fuseImage | input | 512 | Fuse array contents, block i at bits 16i+15:16i |
| protectIn | input | 1 | Global protect configuration level |

## Verification
The hardest case to reach is a second read command, or a change of block number, arriving while a read is still counting down. The bench starts a long read and uses the cycles of busy time to write a new block number and a new read command. It then checks that the remaining busy count is consistent with the first request and that the first block's word arrives. An abort from a mid-read disable is reached the same way: the bench starts a 20-cycle read and drops the enable a few cycles in.

// File: rtl/fuse_ctrl_pkg.sv
package fuse_ctrl_pkg;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_RDATA  = 'h04;
  localparam int OFF_WDATA  = 'h08;
  localparam int OFF_INDEX  = 'h0C;
  localparam int OFF_CMD    = 'h10;
  localparam int OFF_STATUS = 'h14;
  localparam int OFF_WTIME  = 'h20;
  localparam int OFF_RTIME  = 'h24;
  localparam int OFF_DEBNC  = 'h28;

  localparam int EN_BIT      = 6;
  localparam int CMD_PGM_BIT = 0;
  localparam int CMD_RD_BIT  = 1;
  localparam int CMD_CLR_BIT = 2;

  typedef struct packed {
    logic startRead;
    logic finishRead;
  } dpStrobe_t;
endpackage

// File: rtl/fuse_ctrl_fsm.sv
module fuse_ctrl_fsm
  import fuse_ctrl_pkg::*;
#(
  parameter int TIMING_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                cmdRead,
  input  logic                cmdPgm,
  input  logic                cmdClr,
  input  logic [TIMING_W-1:0] rdTiming,
  output logic                rdBusy,
  output logic                pgmBusy,
  output logic                doneFlag,
  output dpStrobe_t           strobe
);
  typedef enum logic {ST_IDLE, ST_READ} state_t;

  state_t              state;
  logic [TIMING_W-1:0] cnt;
  logic                idleOk;

  assign idleOk            = enable && (state == ST_IDLE) && !pgmBusy;
  assign strobe.startRead  = cmdRead && idleOk;
  assign strobe.finishRead = enable && (state == ST_READ) && (cnt == TIMING_W'(1));
  assign rdBusy            = (state == ST_READ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pgmBusy  <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      pgmBusy <= cmdPgm && !cmdRead && idleOk;
      if (!enable) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: if (strobe.startRead) begin
            state <= ST_READ;
            cnt   <= (rdTiming == '0) ? TIMING_W'(1) : rdTiming;
          end
          ST_READ: if (cnt == TIMING_W'(1)) state <= ST_IDLE;
                   else cnt <= cnt - TIMING_W'(1);
          default: state <= ST_IDLE;
        endcase
      end
      if (strobe.finishRead) doneFlag <= 1'b1;
      else if (cmdClr && enable) doneFlag <= 1'b0;
    end
  end

  // R3: a read only begins from an enabled, idle controller
  p_start_from_standby_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdBusy) |-> $past(enable && !pgmBusy));
  // R6: done only falls after a clear command
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(cmdClr));
  // R7: disabling ends any read by the next cycle
  p_disable_aborts_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !rdBusy);
  // R9: program busy never lasts more than one cycle
  p_pgm_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    pgmBusy |=> !pgmBusy);
endmodule

// File: rtl/fuse_ctrl_dp.sv
module fuse_ctrl_dp
  import fuse_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int TIMING_W = 8,
  parameter int BLOCKS   = 32,
  parameter int WORD_W   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWe,
  input  logic [31:0]              regWdata,
  output logic [31:0]              regRdata,
  input  logic [BLOCKS*WORD_W-1:0] fuseImage,
  input  logic                     protectIn,
  input  dpStrobe_t                strobe,
  input  logic                     rdBusy,
  input  logic                     pgmBusy,
  input  logic                     doneFlag,
  output logic                     enable,
  output logic                     cmdRead,
  output logic                     cmdPgm,
  output logic                     cmdClr,
  output logic [TIMING_W-1:0]      rdTiming
);
  localparam int IDX_W = $clog2(BLOCKS);

  logic [WORD_W-1:0]   fuseWord [BLOCKS];
  logic [31:0]         writeData;
  logic [IDX_W-1:0]    blockIdx, latchedIdx;
  logic [TIMING_W-1:0] wrTiming, debCtrl;
  logic [WORD_W-1:0]   readData;
  logic                cmdHit;
  logic [31:0]         statusWord;

  for (genvar g = 0; g < BLOCKS; g++) begin : g_word
    assign fuseWord[g] = fuseImage[g*WORD_W +: WORD_W];
  end

  assign cmdHit  = regWe && (regAddr == ADDR_W'(OFF_CMD));
  assign cmdRead = cmdHit && regWdata[CMD_RD_BIT];
  assign cmdPgm  = cmdHit && regWdata[CMD_PGM_BIT];
  assign cmdClr  = cmdHit && regWdata[CMD_CLR_BIT];

  assign statusWord = {27'd0, doneFlag, protectIn, !rdBusy && !pgmBusy, rdBusy, pgmBusy};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable     <= 1'b0;
      writeData  <= '0;
      blockIdx   <= '0;
      latchedIdx <= '0;
      wrTiming   <= '0;
      rdTiming   <= '0;
      debCtrl    <= '0;
      readData   <= '0;
    end else begin
      if (regWe) begin
        case (int'(regAddr))
          OFF_CTRL:  enable    <= regWdata[EN_BIT];
          OFF_WDATA: writeData <= regWdata;
          OFF_INDEX: blockIdx  <= regWdata[IDX_W-1:0];
          OFF_WTIME: wrTiming  <= regWdata[TIMING_W-1:0];
          OFF_RTIME: rdTiming  <= regWdata[TIMING_W-1:0];
          OFF_DEBNC: debCtrl   <= regWdata[TIMING_W-1:0];
          default: ;
        endcase
      end
      if (strobe.startRead)  latchedIdx <= blockIdx;
      if (strobe.finishRead) readData   <= fuseWord[latchedIdx];
    end
  end

  always_comb begin
    regRdata = '0;
    case (int'(regAddr))
      OFF_CTRL:   regRdata[EN_BIT] = enable;
      OFF_RDATA:  regRdata = 32'(readData);
      OFF_WDATA:  regRdata = writeData;
      OFF_INDEX:  regRdata = 32'(blockIdx);
      OFF_STATUS: regRdata = statusWord;
      OFF_WTIME:  regRdata = 32'(wrTiming);
      OFF_RTIME:  regRdata = 32'(rdTiming);
      OFF_DEBNC:  regRdata = 32'(debCtrl);
      default:    regRdata = '0;
    endcase
  end

  // R6: read data changes only on a completing read
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finishRead |=> $stable(readData));
  // R5: the captured block number stays fixed while a read is running
  p_index_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdBusy && !strobe.startRead |=> $stable(latchedIdx));
endmodule

// File: rtl/fuse_read_ctrl.sv
module fuse_read_ctrl
  import fuse_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int TIMING_W = 8,
  parameter int BLOCKS   = 32,
  parameter int WORD_W   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWe,
  input  logic [31:0]              regWdata,
  output logic [31:0]              regRdata,
  input  logic [BLOCKS*WORD_W-1:0] fuseImage,
  input  logic                     protectIn
);
  dpStrobe_t           strobe;
  logic                enable, cmdRead, cmdPgm, cmdClr;
  logic                rdBusy, pgmBusy, doneFlag;
  logic [TIMING_W-1:0] rdTiming;

  fuse_ctrl_fsm #(.TIMING_W(TIMING_W)) u_fsm (
    .clk(clk), .rstN(rstN), .enable(enable), .cmdRead(cmdRead),
    .cmdPgm(cmdPgm), .cmdClr(cmdClr), .rdTiming(rdTiming),
    .rdBusy(rdBusy), .pgmBusy(pgmBusy), .doneFlag(doneFlag), .strobe(strobe)
  );

  fuse_ctrl_dp #(.ADDR_W(ADDR_W), .TIMING_W(TIMING_W), .BLOCKS(BLOCKS), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .fuseImage(fuseImage),
    .protectIn(protectIn), .strobe(strobe), .rdBusy(rdBusy),
    .pgmBusy(pgmBusy), .doneFlag(doneFlag), .enable(enable),
    .cmdRead(cmdRead), .cmdPgm(cmdPgm), .cmdClr(cmdClr), .rdTiming(rdTiming)
  );
endmodule

// File: tb/fuse_read_ctrl_test.sv
module fuse_read_ctrl_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [5:0]   regAddr = '0;
  logic         regWe = 1'b0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic [511:0] fuseImage;
  logic         protectIn = 1'b0;

  int checks = 0;
  int fails = 0;

  localparam logic [5:0] A_CTRL = 6'h00, A_RDATA = 6'h04, A_WDATA = 6'h08,
    A_INDEX = 6'h0C, A_CMD = 6'h10, A_STATUS = 6'h14, A_WTIME = 6'h20,
    A_RTIME = 6'h24, A_DEBNC = 6'h28;

  // {block number, read timing}
  localparam logic [15:0] VEC [4] = '{16'h00_00, 16'h1F_01, 16'h05_07, 16'h11_03};

  always #4 clk = ~clk;

  fuse_read_ctrl uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .fuseImage(fuseImage),
    .protectIn(protectIn)
  );

  function automatic logic [15:0] wordOf(int i);
    return 16'(i * 16'h0911) ^ 16'hC35A;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [5:0] a, logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic countBusy(output int n);
    logic [31:0] s;
    n = 0;
    for (int k = 0; k < 400; k++) begin
      readReg(A_STATUS, s);
      if (!s[1]) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) fuseImage[i*16 +: 16] = wordOf(i);
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] keep;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(A_STATUS, v); check("R1 status", v, 32'h04);
    readReg(A_RDATA, v);  check("R1 rdata", v, 0);
    readReg(A_INDEX, v);  check("R1 index", v, 0);
    readReg(A_CTRL, v);   check("R1 ctrl", v, 0);

    // R3 read command while disabled is ignored
    writeReg(A_INDEX, 32'd4);
    writeReg(A_CMD, 32'h2);
    readReg(A_STATUS, v); check("R3 disabled status", v, 32'h04);
    @(negedge clk);
    readReg(A_STATUS, v); check("R3 disabled no done", v, 32'h04);
    readReg(A_RDATA, v);  check("R3 disabled rdata", v, 0);

    // R2 register storage
    writeReg(A_INDEX, 32'hFF);    readReg(A_INDEX, v); check("R2 index mask", v, 32'h1F);
    writeReg(A_WDATA, 32'hDEADBEEF); readReg(A_WDATA, v); check("R2 wdata", v, 32'hDEADBEEF);
    writeReg(A_WTIME, 32'h5A);    readReg(A_WTIME, v); check("R2 wtime", v, 32'h5A);
    writeReg(A_DEBNC, 32'h1C3);   readReg(A_DEBNC, v); check("R2 debounce", v, 32'hC3);
    writeReg(A_RTIME, 32'h0);     readReg(A_RTIME, v); check("R2 rtime", v, 0);
    readReg(A_CMD, v); check("R2 cmd reads zero", v, 0);

    writeReg(A_CTRL, 32'h40);
    readReg(A_CTRL, v); check("R1 ctrl enable readback", v, 32'h40);

    // R4 R5 R6 vector table
    foreach (VEC[i]) begin
      int tm;
      tm = (VEC[i][7:0] == 0) ? 1 : int'(VEC[i][7:0]);
      writeReg(A_INDEX, 32'(VEC[i][15:8]));
      writeReg(A_RTIME, 32'(VEC[i][7:0]));
      writeReg(A_CMD, 32'h2);
      readReg(A_STATUS, v); check("R4 standby low while busy", v & 32'h6, 32'h2);
      countBusy(n);
      check("R4 busy length", n, tm);
      readReg(A_STATUS, v); check("R5 done standby", v, 32'h14);
      readReg(A_RDATA, v);  check("R5 word", v, 32'(wordOf(int'(VEC[i][15:8]))));
      writeReg(A_CMD, 32'h4);
      readReg(A_STATUS, v); check("R6 clear", v, 32'h04);
    end

    // R3 R5 command and block change while busy are ignored
    writeReg(A_INDEX, 32'd3);
    writeReg(A_RTIME, 32'd10);
    writeReg(A_CMD, 32'h2);
    writeReg(A_INDEX, 32'd9);
    writeReg(A_CMD, 32'h2);
    countBusy(n);
    check("R3 busy restart ignored", n, 8);
    readReg(A_RDATA, v); check("R5 captured block", v, 32'(wordOf(3)));

    // R6 sticky done and held data
    repeat (5) @(negedge clk);
    readReg(A_STATUS, v); check("R6 done sticky", v, 32'h14);
    writeReg(A_CTRL, 32'h0);
    writeReg(A_CMD, 32'h4);
    readReg(A_STATUS, v); check("R6 clear ignored when disabled", v, 32'h14);
    writeReg(A_CTRL, 32'h40);
    writeReg(A_CMD, 32'h4);
    readReg(A_RDATA, v); check("R6 data held", v, 32'(wordOf(3)));

    // R7 abort
    keep = v;
    writeReg(A_INDEX, 32'd20);
    writeReg(A_RTIME, 32'd20);
    writeReg(A_CMD, 32'h2);
    repeat (3) @(negedge clk);
    writeReg(A_CTRL, 32'h0);
    @(negedge clk);
    readReg(A_STATUS, v); check("R7 abort standby", v, 32'h04);
    readReg(A_RDATA, v);  check("R7 data unchanged", v, keep);
    writeReg(A_CTRL, 32'h40);

    // R8 protect mirror
    protectIn = 1'b1;
    readReg(A_STATUS, v); check("R8 protect high", v, 32'h0C);
    protectIn = 1'b0;
    readReg(A_STATUS, v); check("R8 protect low", v, 32'h04);

    // R9 program pulse
    writeReg(A_CMD, 32'h1);
    readReg(A_STATUS, v); check("R9 pgm busy", v, 32'h01);
    @(negedge clk);
    readReg(A_STATUS, v); check("R9 pgm one cycle", v, 32'h04);
    writeReg(A_INDEX, 32'd3);
    writeReg(A_RTIME, 32'd2);
    writeReg(A_CMD, 32'h2);
    countBusy(n);
    readReg(A_RDATA, v); check("R9 array unchanged", v, 32'(wordOf(3)));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule